// File: doc/BRIEF.md
# Eight-Operation Arithmetic Logic Unit

This block combines two operands of a configurable width under a three-bit operation code. It produces a result of the same width and three status bits: a carry bit, a zero bit and a sign bit. Two codes do arithmetic on both operands, three do bitwise logic on both, and one inverts the first operand. One code adds one to the second operand, and the last one copies the second operand to the result. One ripple chain of full-adder cells does all of the arithmetic. The chain's operands and carry-in are steered for each code, so subtraction and increment need no adder of their own.

The core is combinational. A single output register stage samples its result and flags on each rising clock edge, so every set of inputs shows at the outputs one edge after it is applied. The register has a synchronous active-low reset. The width parameter defaults to 8 bits.

Top module: `eightway_alu`

## Requirements
- R1: Code 3'b000 gives A + B modulo 2^W in the result, and the carry bit holds the bit that falls out of the top of the sum.
- R2: Code 3'b001 gives A - B modulo 2^W, formed as A + ~B + 1. The carry bit is 1 when A >= B as unsigned numbers (no borrow) and 0 otherwise.
- R3: Codes 3'b010, 3'b011 and 3'b100 give A AND B, A OR B and A XOR B, with the carry bit at 0.
- R4: Code 3'b101 gives the bitwise inverse of A with the carry bit at 0. The value of B has no effect on any output.
- R5: Code 3'b110 gives B + 1 modulo 2^W. The carry bit is 1 only when B is all ones. The value of A has no effect on any output.
- R6: Code 3'b111 copies B to the result unchanged, with the carry bit at 0. The value of A has no effect.
- R7: The zero bit is 1 exactly when every bit of the registered result is 0.
- R8: The sign bit always equals the most significant bit of the registered result.
- R9: Outputs change only on a rising clock edge. The inputs present at one rising edge determine the outputs that hold from that edge until the next one.
- R10: A rising edge with rst_n low sets the result, carry, zero and sign outputs all to 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | OPW | First operand |
| opnd_b | input | OPW | Second operand |
| op_code | input | 3 | Operation select |
| result_q | output | OPW | Registered result |
| carry_q | output | 1 | Registered carry / no-borrow bit |
| zero_q | output | 1 | Registered zero bit |
| sign_q | output | 1 | Registered sign bit |

## Verification
The only internal state is the output register. Any fault in the steering or in the adder chain therefore shows up at the ports on the first edge after the faulty inputs are applied. A mis-steered adder input or a wrong carry-in shows as a result that is off by one, or as an inverted carry, but only for the arithmetic codes. A break in the carry chain shows only when a carry has to cross the broken cell. For this reason the stimulus includes carry runs across the full width (all ones plus one, zero minus one) and equal operands under subtraction, besides random operands under every code. A flag bit that drifts from the registered result shows on the same edge as the result.

// File: rtl/eightway_alu_pkg.sv
// Package: operation codes shared by the ALU and its checker.
// Assumes a fixed three-bit code map; the values below define behaviour.
package eightway_alu_pkg;

    localparam int OP_BITS = 3;

    typedef enum logic [OP_BITS-1:0] {
        OPC_ADD  = 3'b000,
        OPC_SUB  = 3'b001,
        OPC_AND  = 3'b010,
        OPC_OR   = 3'b011,
        OPC_XOR  = 3'b100,
        OPC_INVA = 3'b101,
        OPC_INCB = 3'b110,
        OPC_PASB = 3'b111
    } alu_opc_e;

    // True when the code uses the adder chain.
    function automatic logic uses_adder(alu_opc_e opc);
        return (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_INCB);
    endfunction

endpackage

// File: rtl/alu_fa_cell.sv
// Module: one full-adder cell.
// Sum is the three-input XOR; carry is the majority of the three inputs.
module alu_fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and carry of three single bits.
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end

endmodule

// File: rtl/alu_ripple_chain.sv
// Module: ripple-carry adder built from full-adder cells.
// Assumes WIDTH >= 1; the carry enters at bit 0 and leaves from the top cell.
module alu_ripple_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] link;

    // Carry-in feeds the bottom link.
    always_comb link[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_fa_cell u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (link[i]),
            .s  (sum[i]),
            .co (link[i+1])
        );
    end

    // Carry-out taken from the top link.
    always_comb cout = link[WIDTH];

endmodule

// File: rtl/alu_operand_steer.sv
// Module: chooses the adder's inputs and carry-in for each code.
// Add: A + B + 0. Subtract: A + ~B + 1. Increment: B + 0 + 1.
// For non-arithmetic codes the outputs are don't-care and are held at 0.
module alu_operand_steer
    import eightway_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_opc_e         opc,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y,
    output logic             cin
);

    // Per-code steering of adder inputs.
    always_comb begin
        x   = '0;
        y   = '0;
        cin = 1'b0;
        unique case (opc)
            OPC_ADD: begin
                x = a;
                y = b;
            end
            OPC_SUB: begin
                x   = a;
                y   = ~b;
                cin = 1'b1;
            end
            OPC_INCB: begin
                x   = b;
                cin = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise functions and the transfer path.
// Returns 0 for arithmetic codes; the top selects the adder then.
module alu_logic_unit
    import eightway_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_opc_e         opc,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] r
);

    // Bitwise result by code.
    always_comb begin
        unique case (opc)
            OPC_AND:  r = a & b;
            OPC_OR:   r = a | b;
            OPC_XOR:  r = a ^ b;
            OPC_INVA: r = ~a;
            OPC_PASB: r = b;
            default:  r = '0;
        endcase
    end

endmodule

// File: rtl/eightway_alu.sv
// Module: eight-operation ALU with one registered output stage.
// Assumes a synchronous active-low reset and OPW >= 1. The core is
// combinational; result and flags are captured on each rising edge.
module eightway_alu
    import eightway_alu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opnd_a,
    input  logic [OPW-1:0] opnd_b,
    input  logic [2:0]     op_code,
    output logic [OPW-1:0] result_q,
    output logic           carry_q,
    output logic           zero_q,
    output logic           sign_q
);

    localparam int MSB = OPW - 1;

    alu_opc_e       opc;
    logic [OPW-1:0] add_x;
    logic [OPW-1:0] add_y;
    logic           add_ci;
    logic [OPW-1:0] add_sum;
    logic           add_co;
    logic [OPW-1:0] lu_r;
    logic [OPW-1:0] res_d;
    logic           carry_d;
    logic           zero_d;
    logic           sign_d;

    // Interpret the raw select as an operation code.
    always_comb opc = alu_opc_e'(op_code);

    alu_operand_steer #(.WIDTH(OPW)) u_steer (
        .opc (opc),
        .a   (opnd_a),
        .b   (opnd_b),
        .x   (add_x),
        .y   (add_y),
        .cin (add_ci)
    );

    alu_ripple_chain #(.WIDTH(OPW)) u_chain (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_ci),
        .sum  (add_sum),
        .cout (add_co)
    );

    alu_logic_unit #(.WIDTH(OPW)) u_logic (
        .opc (opc),
        .a   (opnd_a),
        .b   (opnd_b),
        .r   (lu_r)
    );

    // Pick the adder or the logic path; carry only from arithmetic codes.
    always_comb begin
        if (uses_adder(opc)) begin
            res_d   = add_sum;
            carry_d = add_co;
        end else begin
            res_d   = lu_r;
            carry_d = 1'b0;
        end
    end

    // Status flags derived from the selected result.
    always_comb begin
        zero_d = (res_d == '0);
        sign_d = res_d[MSB];
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            carry_q  <= 1'b0;
            zero_q   <= 1'b0;
            sign_q   <= 1'b0;
        end else begin
            result_q <= res_d;
            carry_q  <= carry_d;
            zero_q   <= zero_d;
            sign_q   <= sign_d;
        end
    end

endmodule

// File: rtl/eightway_alu_chk.sv
// Module: assertion checker for eightway_alu, attached by bind.
// Compares registered outputs against the previous edge's inputs.
module eightway_alu_chk #(
    parameter int OPW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] opnd_a,
    input logic [OPW-1:0] opnd_b,
    input logic [2:0]     op_code,
    input logic [OPW-1:0] result_q,
    input logic           carry_q,
    input logic           zero_q,
    input logic           sign_q
);

    logic live_q;
    logic was_rst_q;

    // live_q: previous edge saw rst_n high; was_rst_q: previous edge saw it low.
    always_ff @(posedge clk) begin
        live_q    <= rst_n;
        was_rst_q <= ~rst_n;
    end

    assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b000) |->
        {carry_q, result_q} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}));

    assert_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b001) |->
        (result_q == OPW'($past(opnd_a) - $past(opnd_b)) &&
         carry_q == ($past(opnd_a) >= $past(opnd_b))));

    assert_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b010) |->
        (result_q == ($past(opnd_a) & $past(opnd_b)) && !carry_q));

    assert_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b011) |->
        (result_q == ($past(opnd_a) | $past(opnd_b)) && !carry_q));

    assert_xor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b100) |->
        (result_q == ($past(opnd_a) ^ $past(opnd_b)) && !carry_q));

    assert_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b101) |->
        (result_q == ~$past(opnd_a) && !carry_q));

    assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b110) |->
        (result_q == OPW'($past(opnd_b) + 1'b1) && carry_q == (&$past(opnd_b))));

    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1 && $past(op_code) == 3'b111) |->
        (result_q == $past(opnd_b) && !carry_q));

    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1) |-> (zero_q == (result_q == '0)));

    assert_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q === 1'b1) |-> (sign_q == result_q[OPW-1]));

    assert_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst_q === 1'b1) |->
        (result_q == '0 && !carry_q && !zero_q && !sign_q));

endmodule

bind eightway_alu eightway_alu_chk #(.OPW(OPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_code  (op_code),
    .result_q (result_q),
    .carry_q  (carry_q),
    .zero_q   (zero_q),
    .sign_q   (sign_q)
);

// File: tb/eightway_alu_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor checks them.
module eightway_alu_test;

    localparam int W = 8;
    localparam logic [W-1:0] ONES = '1;

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] res;
        logic         cy;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = '0;
    logic [W-1:0] res_q;
    logic         cy_q, zf_q, sf_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];

    eightway_alu #(.OPW(W)) uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .op_code(op),
        .result_q(res_q), .carry_q(cy_q), .zero_q(zf_q), .sign_q(sf_q)
    );

    always #2 clk = ~clk;

    function automatic string req_of(logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010, 3'b011, 3'b100: return "R3";
            3'b101: return "R4";
            3'b110: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
        exp_t e;
        logic [W:0] wide;
        e.op = o;
        e.cy = 1'b0;
        case (o)
            3'b000: begin wide = {1'b0, x} + {1'b0, y}; e.res = wide[W-1:0]; e.cy = wide[W]; end
            3'b001: begin e.res = x - y; e.cy = (x >= y); end
            3'b010: e.res = x & y;
            3'b011: e.res = x | y;
            3'b100: e.res = x ^ y;
            3'b101: e.res = ~x;
            3'b110: begin e.res = y + 1'b1; e.cy = (y == ONES); end
            default: e.res = y;
        endcase
        return e;
    endfunction

    task automatic check(string req, logic [W:0] got, logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Driver: apply inputs at the falling edge and queue the expectation.
    task automatic drive(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        sb.push_back(model(o, x, y));
    endtask

    // Monitor: one edge after the inputs (R9), compare the next queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check({req_of(e.op), "+R9"}, {cy_q, res_q}, {e.cy, e.res});
                check("R7", {{W{1'b0}}, zf_q}, {{W{1'b0}}, (e.res == '0)});
                check("R8", {{W{1'b0}}, sf_q}, {{W{1'b0}}, e.res[W-1]});
            end
        end
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Reset check R10: outputs cleared regardless of inputs.
    task automatic reset_check();
        drain();
        rst_n = 1'b0; op = 3'b000; a = ONES; b = ONES;
        @(negedge clk);
        check("R10", {cy_q, res_q}, '0);
        check("R10", {{W{1'b0}}, zf_q}, '0);
        check("R10", {{W{1'b0}}, sf_q}, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", {cy_q, res_q}, '0);
        check("R10", {{W{1'b0}}, zf_q}, '0);
        rst_n = 1'b1;
        // R1 carry across full width and plain sums
        drive(3'b000, ONES, 8'h01);
        drive(3'b000, 8'h3c, 8'h44);
        drive(3'b000, 8'h80, 8'h80);
        // R2 equal, borrow, no borrow
        drive(3'b001, 8'h55, 8'h55);
        drive(3'b001, 8'h00, 8'h01);
        drive(3'b001, 8'hf0, 8'h0f);
        // R3 logic
        drive(3'b010, 8'hcc, 8'haa);
        drive(3'b011, 8'h0c, 8'ha0);
        drive(3'b100, 8'hff, 8'h0f);
        // R4 inverse with different B values: B must not matter
        drive(3'b101, 8'h0f, 8'h00);
        drive(3'b101, 8'h0f, 8'hff);
        drive(3'b101, ONES, 8'h5a);
        // R5 increment, wrap at all ones, A must not matter
        drive(3'b110, 8'h12, ONES);
        drive(3'b110, 8'hff, 8'h7f);
        drive(3'b110, 8'h00, 8'h7f);
        // R6 transfer B
        drive(3'b111, 8'hff, 8'h00);
        drive(3'b111, 8'h00, 8'h81);
        reset_check();
        for (int i = 0; i < 400; i++)
            drive(3'($urandom_range(7)), W'($urandom), W'($urandom));
        reset_check();
        drive(3'b001, 8'h7f, 8'h80);
        drain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule